// File: doc/BRIEF.md
# Byte-Serial Sample FIFO with Programmable Fill Thresholds

This block buffers 16-bit conversion results from an acquisition front end and hands them to a host over one 8-bit data port. The converter pushes whole words with a valid strobe. The host drains each word as two byte reads, low half first. A sample leaves the buffer only once its high byte has been read.

The same data port loads two fill thresholds. A clear command empties the buffer and arms a four-byte load sequence. The near-full threshold counts free bytes, not stored bytes. To be told when N bytes are held, load the byte capacity minus N. The block drives empty, full, near-empty and near-full levels. It also drives two sticky events: threshold reached and data lost. Both hold until the next clear.

Top module: `byte_sample_fifo`

## Requirements
- R1: After reset the buffer is empty, both events are low and `host_rdata` is 0. The near-full threshold is half the byte capacity (`DEPTH` bytes) and the near-empty threshold is 0.
- R2: A `cnv_valid` cycle stores `cnv_data` when the buffer is not full. Samples leave in arrival order.
- R3: Each host read returns one byte on `host_rdata` in the cycle after the `host_rd` strobe. The byte order within a sample is bits 7:0, then bits 15:8. The sample is removed only by the high-byte read, so the fill level and the flags do not change after a low-byte read.
- R4: A read while the buffer is empty returns 0. It leaves the byte phase unchanged, so the next sample still starts with its low byte.
- R5: A push in a cycle where the buffer is full is dropped, even if a read pops a sample in the same cycle. It sets `evt_data_lost`, which stays high until a clear.
- R6: `fifo_clear` empties the buffer, returns the byte phase to low and clears both events. It wins over a push, read or write in the same cycle.
- R7: The first four `host_wr` bytes after a clear load the thresholds in this order: near-empty low, near-empty high, near-full low, near-full high. Further writes, and writes made before any clear, are ignored. A clear keeps the loaded threshold values.
- R8: `flag_near_full` is high while the free bytes are at or below the near-full threshold. Free bytes are 2·DEPTH − 2·(samples held).
- R9: `flag_near_empty` is high while the stored bytes (2·samples held) are at or below the near-empty threshold.
- R10: `flag_empty` is high exactly when no sample is held. `flag_full` is high exactly when `DEPTH` samples are held.
- R11: `evt_threshold` goes high in the cycle after `flag_near_full` is seen high and stays high until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_valid | input | 1 | Converter push strobe |
| cnv_data | input | 16 | Converter sample |
| fifo_clear | input | 1 | Empty the buffer and arm the threshold load |
| host_rd | input | 1 | Host byte read strobe |
| host_wr | input | 1 | Host byte write strobe (threshold load) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte returned by the last read |
| flag_empty | output | 1 | No sample held |
| flag_full | output | 1 | Buffer holds DEPTH samples |
| flag_near_empty | output | 1 | Stored bytes at or below the near-empty threshold |
| flag_near_full | output | 1 | Free bytes at or below the near-full threshold |
| evt_threshold | output | 1 | Sticky: near-full was reached |
| evt_data_lost | output | 1 | Sticky: a sample was dropped while full |

## Verification
The bench builds the block with `DEPTH = 8`, which gives a 16-byte capacity and takes the non-power-of-two pointer variant off the table. At that size it can sweep every near-full threshold from 0 to 17 free bytes. For each threshold it also loads the mirrored near-empty threshold and walks every fill level from empty to full, so each threshold comparison is checked at its exact crossing point. Each pass ends with an overflow push and a full drain. That drain checks every byte in order, confirms the dropped sample never appears, and checks that the flags do not move after a low-byte read.

// File: rtl/byte_fifo_pkg.sv
package byte_fifo_pkg;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 2 * BYTE_W;
   localparam int THR_W  = 2 * BYTE_W;
   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [WORD_W-1:0] word_t;
   typedef logic [THR_W-1:0]  thr_t;
endpackage

// File: rtl/byte_fifo_store.sv
module byte_fifo_store
   import byte_fifo_pkg::*;
#(
   parameter int DEPTH = 2048,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push_req,
   input  word_t            push_data,
   input  logic             pop,
   output word_t            head,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

   word_t            mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             push_ok;

   assign full    = (count == DEPTH_C);
   assign empty   = (count == '0);
   // A push is judged against the fill level at the start of the cycle.
   assign push_ok = push_req && !full && !clr;
   assign head    = mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == LAST_P) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == LAST_P) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop)     rd_ptr <= rd_nxt;
         case ({push_ok, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end
endmodule

// File: rtl/byte_fifo_reader.sv
module byte_fifo_reader
   import byte_fifo_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  clr,
   input  logic  rd_req,
   input  logic  empty,
   input  word_t head,
   output byte_t rdata,
   output logic  pop
);
   logic hi_phase;

   assign pop = rd_req && !empty && hi_phase && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata    <= '0;
         hi_phase <= 1'b0;
      end else if (clr) begin
         rdata    <= '0;
         hi_phase <= 1'b0;
      end else if (rd_req) begin
         if (empty) begin
            rdata <= '0;
         end else begin
            rdata    <= hi_phase ? head[WORD_W-1:BYTE_W] : head[BYTE_W-1:0];
            hi_phase <= ~hi_phase;
         end
      end
   end
endmodule

// File: rtl/byte_fifo_thresh.sv
module byte_fifo_thresh
   import byte_fifo_pkg::*;
#(
   parameter thr_t DEF_NEAR_EMPTY = '0,
   parameter thr_t DEF_NEAR_FULL  = 16'd2048
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  clr,
   input  logic  wr_req,
   input  byte_t wdata,
   output thr_t  ne_thr,
   output thr_t  nf_thr
);
   localparam logic [2:0] DISARMED = 3'd4;
   logic [2:0] slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot   <= DISARMED;
         ne_thr <= DEF_NEAR_EMPTY;
         nf_thr <= DEF_NEAR_FULL;
      end else if (clr) begin
         slot <= '0;
      end else if (wr_req && slot != DISARMED) begin
         case (slot[1:0])
            2'd0: ne_thr[BYTE_W-1:0]     <= wdata;
            2'd1: ne_thr[THR_W-1:BYTE_W] <= wdata;
            2'd2: nf_thr[BYTE_W-1:0]     <= wdata;
            default: nf_thr[THR_W-1:BYTE_W] <= wdata;
         endcase
         slot <= slot + 1'b1;
      end
   end
endmodule

// File: rtl/byte_sample_fifo.sv
module byte_sample_fifo
   import byte_fifo_pkg::*;
#(
   parameter int DEPTH = 2048,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int CAP_BYTES = 2 * DEPTH
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cnv_valid,
   input  logic [15:0] cnv_data,
   input  logic        fifo_clear,
   input  logic        host_rd,
   input  logic        host_wr,
   input  logic [7:0]  host_wdata,
   output logic [7:0]  host_rdata,
   output logic        flag_empty,
   output logic        flag_full,
   output logic        flag_near_empty,
   output logic        flag_near_full,
   output logic        evt_threshold,
   output logic        evt_data_lost
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("byte_sample_fifo: DEPTH must be at least 2");
      end
      if (CAP_BYTES > 65535) begin : g_bad_cap
         $error("byte_sample_fifo: byte capacity exceeds threshold width");
      end
   endgenerate

   localparam thr_t CAP_T = THR_W'(CAP_BYTES);

   word_t            head;
   logic [CNT_W-1:0] count;
   logic             pop;
   thr_t             ne_thr, nf_thr, stored_b, free_b;

   byte_fifo_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(fifo_clear),
      .push_req(cnv_valid), .push_data(cnv_data), .pop(pop),
      .head(head), .count(count), .full(flag_full), .empty(flag_empty)
   );

   byte_fifo_reader u_reader (
      .clk(clk), .rst_n(rst_n), .clr(fifo_clear), .rd_req(host_rd),
      .empty(flag_empty), .head(head), .rdata(host_rdata), .pop(pop)
   );

   byte_fifo_thresh #(
      .DEF_NEAR_EMPTY('0),
      .DEF_NEAR_FULL(THR_W'(DEPTH))
   ) u_thresh (
      .clk(clk), .rst_n(rst_n), .clr(fifo_clear), .wr_req(host_wr),
      .wdata(host_wdata), .ne_thr(ne_thr), .nf_thr(nf_thr)
   );

   assign stored_b        = THR_W'({count, 1'b0});
   assign free_b          = CAP_T - stored_b;
   assign flag_near_full  = (free_b <= nf_thr);
   assign flag_near_empty = (stored_b <= ne_thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_threshold <= 1'b0;
         evt_data_lost <= 1'b0;
      end else if (fifo_clear) begin
         evt_threshold <= 1'b0;
         evt_data_lost <= 1'b0;
      end else begin
         if (flag_near_full)          evt_threshold <= 1'b1;
         if (cnv_valid && flag_full)  evt_data_lost <= 1'b1;
      end
   end
endmodule

// File: rtl/byte_sample_fifo_chk.sv
module byte_sample_fifo_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cnv_valid,
   input logic       fifo_clear,
   input logic       host_rd,
   input logic [7:0] host_rdata,
   input logic       flag_empty,
   input logic       flag_full,
   input logic       flag_near_full,
   input logic       evt_threshold,
   input logic       evt_data_lost
);
   assert_full_not_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(flag_full && flag_empty));

   assert_lost_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_data_lost) |-> $past(cnv_valid && flag_full && !fifo_clear));

   assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && flag_empty && !fifo_clear) |=> (host_rdata == 8'h00));

   assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clear |=> (flag_empty && !evt_data_lost && !evt_threshold));

   assert_thr_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_threshold) |-> $past(flag_near_full));

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnv_valid && !host_rd && !fifo_clear) |=> ($stable(flag_empty) && $stable(flag_full)));
endmodule

bind byte_sample_fifo byte_sample_fifo_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cnv_valid(cnv_valid), .fifo_clear(fifo_clear),
   .host_rd(host_rd), .host_rdata(host_rdata), .flag_empty(flag_empty),
   .flag_full(flag_full), .flag_near_full(flag_near_full),
   .evt_threshold(evt_threshold), .evt_data_lost(evt_data_lost)
);

// File: tb/byte_sample_fifo_tb.sv
module byte_sample_fifo_tb;
   localparam int D   = 8;
   localparam int CAP = 2 * D;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnv_valid = 1'b0;
   logic [15:0] cnv_data = '0;
   logic        fifo_clear = 1'b0;
   logic        host_rd = 1'b0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        flag_empty, flag_full, flag_near_empty, flag_near_full;
   logic        evt_threshold, evt_data_lost;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   byte_sample_fifo #(.DEPTH(D)) u_dut (
      .clk(clk), .rst_n(rst_n), .cnv_valid(cnv_valid), .cnv_data(cnv_data),
      .fifo_clear(fifo_clear), .host_rd(host_rd), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .flag_empty(flag_empty), .flag_full(flag_full),
      .flag_near_empty(flag_near_empty), .flag_near_full(flag_near_full),
      .evt_threshold(evt_threshold), .evt_data_lost(evt_data_lost)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic push(input logic [15:0] d);
      @(negedge clk); cnv_valid = 1'b1; cnv_data = d;
      @(negedge clk); cnv_valid = 1'b0;
   endtask

   task automatic rd_byte(output logic [7:0] b);
      @(negedge clk); host_rd = 1'b1;
      @(negedge clk); host_rd = 1'b0; b = host_rdata;
   endtask

   task automatic wr_byte(input logic [7:0] b);
      @(negedge clk); host_wr = 1'b1; host_wdata = b;
      @(negedge clk); host_wr = 1'b0;
   endtask

   task automatic do_clear();
      @(negedge clk); fifo_clear = 1'b1;
      @(negedge clk); fifo_clear = 1'b0;
   endtask

   function automatic logic [15:0] sval(input int t, input int k);
      return {8'(t * 16 + k), 8'(k * 37 + t + 5)};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      // R1 reset state
      chk(flag_empty == 1'b1, "R1 empty", flag_empty, 1);
      chk(evt_threshold == 1'b0 && evt_data_lost == 1'b0, "R1 events", {evt_threshold, evt_data_lost}, 0);
      chk(host_rdata == 8'h00, "R1 rdata", host_rdata, 0);
      chk(flag_near_empty == 1'b1, "R1 near-empty default", flag_near_empty, 1);
      // R1 default near-full = D free bytes: level D/2 samples gives CAP-D = D free
      for (int k = 1; k <= D / 2; k++) begin
         push(16'(k));
         idle();
         chk(flag_near_full == (CAP - 2 * k <= D), "R1 default near-full", flag_near_full, int'(CAP - 2 * k <= D));
         chk(flag_near_empty == 1'b0, "R9 default near-empty", flag_near_empty, 0);
      end
      // R7 writes before any clear are ignored: 0xFF bytes would raise near-full at level 0
      do_clear();
      do_clear();
      idle();
      chk(flag_empty == 1'b1, "R6 clear empties", flag_empty, 1);
      rst_n = 1'b0; idle(); rst_n = 1'b1; idle();
      for (int i = 0; i < 4; i++) wr_byte(8'hFF);
      idle();
      chk(flag_near_full == 1'b0, "R7 write before clear ignored", flag_near_full, 0);

      // Sweep near-full thresholds and every fill level
      for (int t = 0; t <= CAP + 1; t++) begin
         int nf, ne;
         bit ever;
         nf = t; ne = CAP - t; if (ne < 0) ne = 0;
         do_clear();
         wr_byte(8'(ne)); wr_byte(8'(ne >> 8));
         wr_byte(8'(nf)); wr_byte(8'(nf >> 8));
         wr_byte(8'hFF);   // R7 fifth write ignored
         do_clear();
         idle();
         ever = (CAP <= nf);
         chk(flag_near_full == (CAP <= nf), "R8 level 0", flag_near_full, int'(CAP <= nf));
         chk(flag_near_empty == 1'b1, "R9 level 0", flag_near_empty, 1);
         chk(evt_threshold == ever, "R11 level 0", evt_threshold, int'(ever));
         for (int k = 1; k <= D; k++) begin
            push(sval(t, k));
            idle();
            if (CAP - 2 * k <= nf) ever = 1'b1;
            chk(flag_near_full == (CAP - 2 * k <= nf), "R8 R7 near-full", flag_near_full, int'(CAP - 2 * k <= nf));
            chk(flag_near_empty == (2 * k <= ne), "R9 R7 near-empty", flag_near_empty, int'(2 * k <= ne));
            chk(flag_full == (k == D) && flag_empty == 1'b0, "R10 flags", {flag_full, flag_empty}, {1'b0, int'(k == D) != 0});
            chk(evt_threshold == ever, "R11 sticky", evt_threshold, int'(ever));
         end
         chk(evt_data_lost == 1'b0, "R5 no loss yet", evt_data_lost, 0);
         // R5 overflow; the push coincides with a low-byte read (no pop)
         @(negedge clk); cnv_valid = 1'b1; cnv_data = 16'hDEAD; host_rd = 1'b1;
         @(negedge clk); cnv_valid = 1'b0; host_rd = 1'b0; b = host_rdata;
         chk(b == sval(t, 1)[7:0], "R3 low first", b, sval(t, 1)[7:0]);
         chk(evt_data_lost == 1'b1, "R5 lost set", evt_data_lost, 1);
         chk(flag_full == 1'b1, "R3 no pop on low byte", flag_full, 1);
         rd_byte(b);
         chk(b == sval(t, 1)[15:8], "R3 high byte", b, sval(t, 1)[15:8]);
         for (int k = 2; k <= D; k++) begin
            rd_byte(b);
            chk(b == sval(t, k)[7:0], "R2 R3 low byte", b, sval(t, k)[7:0]);
            chk(flag_empty == 1'b0, "R3 held until high", flag_empty, 0);
            rd_byte(b);
            chk(b == sval(t, k)[15:8], "R2 R3 high byte", b, sval(t, k)[15:8]);
         end
         chk(flag_empty == 1'b1, "R10 drained, dropped sample absent", flag_empty, 1);
         chk(evt_data_lost == 1'b1, "R5 lost sticky", evt_data_lost, 1);
         rd_byte(b);
         chk(b == 8'h00, "R4 empty read zero", b, 0);
      end

      // R4 empty read leaves phase: next sample starts low
      do_clear();
      chk(evt_data_lost == 1'b0 && evt_threshold == 1'b0, "R6 events cleared", {evt_threshold, evt_data_lost}, 0);
      rd_byte(b);
      push(16'hBEEF);
      rd_byte(b);
      chk(b == 8'hEF, "R4 phase kept", b, 8'hEF);
      // R6 clear resets phase
      do_clear();
      push(16'h1234);
      rd_byte(b);
      chk(b == 8'h34, "R6 phase reset", b, 8'h34);
      // R6 clear beats a same-cycle push
      @(negedge clk); fifo_clear = 1'b1; cnv_valid = 1'b1; cnv_data = 16'h5555;
      @(negedge clk); fifo_clear = 1'b0; cnv_valid = 1'b0;
      chk(flag_empty == 1'b1, "R6 clear wins over push", flag_empty, 1);
      // R7 thresholds survive clear: last sweep left nf=CAP+1, so near-full is high when empty
      idle();
      chk(flag_near_full == 1'b1, "R7 kept over clear", flag_near_full, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule